// File: doc/BRIEF.md
# Write Status Bit Generator

This block belongs in the read path of a flash memory model. It produces the byte that a host sees while an internal program or erase is in progress. A one-cycle `start` pulse marks the final command write that launches an operation. The pulse carries the operation code and the byte being programmed. A busy timer then runs for a length set by a parameter for each operation. While the timer runs, bit 7 of every read reports completion status and bit 6 flips on every read access. A host can therefore poll until bit 7 matches its expectation, or until bit 6 stops changing.

When the timer expires, bit 7 at once reports the true stored value. The rest of the byte stays unsettled for a fixed number of cycles. After that, the true data from the array passes straight through. The array contents and the bus tristate control are outside this block: `true_data` comes from the array and `rd_data` goes to the output driver. The default cycle counts assume a 50 MHz model clock, which keeps the program time within a 20 µs bound.

Top module: `wr_status_gen`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` equals `true_data`.
- R2: A `start` pulse while idle begins an operation. `busy` rises on the next cycle and stays high for exactly PROG_CYCLES cycles (op 2'b00, program), SECT_CYCLES cycles (op 2'b01, sector erase) or CHIP_CYCLES cycles (op 2'b10 or 2'b11, chip erase).
- R3: While a program is busy, `rd_data[7]` is the complement of bit 7 of the byte given with `start`.
- R4: While an erase is busy, `rd_data[7]` is 0.
- R5: While busy, `rd_data[6]` is 1 on the first read after `start` and flips after every cycle with `rd_stb` high. `rd_data[5:0]` reads 0.
- R6: A `start` pulse while busy is ignored. The busy length, the operation and the latched program bit are all unchanged.
- R7: For SETTLE_CYCLES cycles after `busy` falls, `rd_data[7]` equals `true_data[7]`, `rd_data[6]` holds its last value without toggling even when read, and `rd_data[5:0]` reads 0.
- R8: Once the settle window ends, and whenever the block is idle, `rd_data` equals `true_data`.
- R9: A `start` pulse during the settle window ends the window and begins a new operation, as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse on the write that launches an operation |
| op | input | 2 | Operation code: 00 program, 01 sector erase, 1x chip erase |
| prog_data | input | 8 | Byte being programmed (only bit 7 is used) |
| rd_stb | input | 1 | One cycle per host read access |
| true_data | input | 8 | Stored byte at the address being read |
| rd_data | output | 8 | Byte to drive on the data bus |
| busy | output | 1 | Internal operation in progress |

## Verification
Directed sequences cover each operation code. Program runs use written bit 7 set and clear, which separates the complement behaviour from the fixed zero of an erase. Back-to-back reads are compared with sparse reads, which shows that bit 6 follows read accesses and not clock cycles. Extra reads during the settle window check that the toggle stays frozen there. Starts issued during busy and during settle show the difference between an ignored command and a new one. A random phase with a fixed seed mixes start pulses, operation codes, read strobes and array data. Every cycle of that phase is compared against a bench model of the requirements.

// File: rtl/wsg_pkg.sv
// Shared types for the write status bit generator.
package wsg_pkg;
    typedef enum logic [1:0] {
        OP_PROG     = 2'b00,
        OP_SECT     = 2'b01,
        OP_CHIP     = 2'b10,
        OP_CHIP_ALT = 2'b11
    } wsg_op_e;
endpackage

// File: rtl/wsg_timer.sv
// Busy and settle timer with operation context latch.
// Accepts start only while not busy. It loads the busy count for the
// operation, then runs a settle window after completion.
// Assumes every cycle count parameter is at least 1.
module wsg_timer
    import wsg_pkg::*;
#(
    parameter int PROG_CYCLES   = 800,
    parameter int SECT_CYCLES   = 2000,
    parameter int CHIP_CYCLES   = 4000,
    parameter int SETTLE_CYCLES = 50
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  wsg_op_e op_i,
    input  logic    pbit7_i,
    output logic    busy_o,
    output logic    settle_o,
    output wsg_op_e op_o,
    output logic    pbit7_o
);
    localparam int MAXC_A = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int MAXC   = (MAXC_A > CHIP_CYCLES) ? MAXC_A : CHIP_CYCLES;
    localparam int CW     = $clog2(MAXC + 1);
    localparam int SW     = $clog2(SETTLE_CYCLES + 1);

    logic          busy_q, settle_q, pbit7_q;
    logic [CW-1:0] cnt_q, load_val;
    logic [SW-1:0] scnt_q;
    wsg_op_e       op_q;

    // Pick the busy length (minus one) for the requested operation.
    always_comb begin
        case (op_i)
            OP_PROG: load_val = CW'(PROG_CYCLES - 1);
            OP_SECT: load_val = CW'(SECT_CYCLES - 1);
            default: load_val = CW'(CHIP_CYCLES - 1);
        endcase
    end

    // Run the busy countdown, then the settle countdown, and accept new starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            settle_q <= 1'b0;
            cnt_q    <= '0;
            scnt_q   <= '0;
            op_q     <= OP_PROG;
            pbit7_q  <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q   <= 1'b0;
                settle_q <= 1'b1;
                scnt_q   <= SW'(SETTLE_CYCLES - 1);
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else begin
            if (settle_q) begin
                if (scnt_q == '0) settle_q <= 1'b0;
                else              scnt_q   <= scnt_q - 1'b1;
            end
            if (start) begin
                busy_q   <= 1'b1;
                settle_q <= 1'b0;
                cnt_q    <= load_val;
                op_q     <= op_i;
                pbit7_q  <= pbit7_i;
            end
        end
    end

    assign busy_o   = busy_q;
    assign settle_o = settle_q;
    assign op_o     = op_q;
    assign pbit7_o  = pbit7_q;

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && start |=> busy_q);
    a_r6_busy_context_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && cnt_q != '0 |=> busy_q && $stable(op_q) && $stable(pbit7_q));
    a_r7_settle_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> settle_q);
endmodule

// File: rtl/wsg_toggle.sv
// Toggle bit source: set to 1 when an operation is accepted, flipped on
// each read while busy, and held at every other time.
// Assumes start_acc is high only when a start is taken while idle.
module wsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic busy,
    input  logic rd_stb,
    output logic tog_o
);
    logic tog_q;

    // Preset on a new operation, flip once per read access while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog_q <= 1'b1;
        else if (start_acc)      tog_q <= 1'b1;
        else if (busy && rd_stb) tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;

    a_r5_preset_high: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> tog_q);
    a_r5_flip_per_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_stb |=> tog_q != $past(tog_q));
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start_acc |=> $stable(tog_q));
endmodule

// File: rtl/wsg_mux.sv
// Output byte composer. Status byte while busy, bit 7 only during the
// settle window, otherwise the array byte unchanged.
// Purely combinational; settle and busy are never both high.
module wsg_mux
    import wsg_pkg::*;
(
    input  logic       busy,
    input  logic       settle,
    input  wsg_op_e    op,
    input  logic       pbit7,
    input  logic       tog,
    input  logic [7:0] true_data,
    output logic [7:0] rd_data
);
    // Choose the status encoding that applies to the current phase.
    always_comb begin
        if (busy)
            rd_data = {(op == OP_PROG) ? ~pbit7 : 1'b0, tog, 6'b0};
        else if (settle)
            rd_data = {true_data[7], tog, 6'b0};
        else
            rd_data = true_data;
    end
endmodule

// File: rtl/wr_status_gen.sv
// Write status bit generator top. Joins the timer, toggle source and
// output composer. Assumes start is a one-cycle pulse from the command
// decoder and rd_stb is one cycle per host read.
module wr_status_gen
    import wsg_pkg::*;
#(
    parameter int PROG_CYCLES   = 800,
    parameter int SECT_CYCLES   = 2000,
    parameter int CHIP_CYCLES   = 4000,
    parameter int SETTLE_CYCLES = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    input  logic [7:0] prog_data,
    input  logic       rd_stb,
    input  logic [7:0] true_data,
    output logic [7:0] rd_data,
    output logic       busy
);
    logic    busy_w, settle_w, pbit7_w, tog_w;
    wsg_op_e op_w;

    wsg_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .SECT_CYCLES  (SECT_CYCLES),
        .CHIP_CYCLES  (CHIP_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_i    (wsg_op_e'(op)),
        .pbit7_i (prog_data[7]),
        .busy_o  (busy_w),
        .settle_o(settle_w),
        .op_o    (op_w),
        .pbit7_o (pbit7_w)
    );

    wsg_toggle toggle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_acc(start && !busy_w),
        .busy     (busy_w),
        .rd_stb   (rd_stb),
        .tog_o    (tog_w)
    );

    wsg_mux mux_i (
        .busy     (busy_w),
        .settle   (settle_w),
        .op       (op_w),
        .pbit7    (pbit7_w),
        .tog      (tog_w),
        .true_data(true_data),
        .rd_data  (rd_data)
    );

    assign busy = busy_w;

    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w && !settle_w |-> rd_data == true_data);
    a_r4_erase_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w && op_w != OP_PROG |-> !rd_data[7]);
endmodule

// File: tb/wr_status_gen_tb_top.sv
module wr_status_gen_tb_top;
    localparam int PROG_C = 6;
    localparam int SECT_C = 11;
    localparam int CHIP_C = 17;
    localparam int SET_C  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] prog_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] true_data = 8'h00;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    bit         m_busy = 1'b0;
    int         m_rem = 0;
    int         m_set = 0;
    bit         m_tog = 1'b1;
    logic [1:0] m_op = 2'b00;
    bit         m_b7 = 1'b0;

    always #2.5 clk = ~clk;

    wr_status_gen #(
        .PROG_CYCLES  (PROG_C),
        .SECT_CYCLES  (SECT_C),
        .CHIP_CYCLES  (CHIP_C),
        .SETTLE_CYCLES(SET_C)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .prog_data(prog_data),
        .rd_stb   (rd_stb),
        .true_data(true_data),
        .rd_data  (rd_data),
        .busy     (busy)
    );

    function automatic int op_len(logic [1:0] o);
        return (o == 2'b00) ? PROG_C : (o == 2'b01) ? SECT_C : CHIP_C;
    endfunction

    function automatic logic [7:0] exp_byte(logic [7:0] td);
        if (m_busy)      return {(m_op == 2'b00) ? ~m_b7 : 1'b0, m_tog, 6'b0};
        else if (m_set > 0) return {td[7], m_tog, 6'b0};
        else             return td;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // one cycle: drive at negedge, check before next posedge, advance model
    task automatic step(bit st, logic [1:0] o, logic [7:0] pd, bit rd, logic [7:0] td);
        logic [7:0] e;
        @(negedge clk);
        start = st; op = o; prog_data = pd; rd_stb = rd; true_data = td;
        #1;
        e = exp_byte(td);
        chk("R2 busy", {7'b0, busy}, {7'b0, m_busy});
        if (m_busy) begin
            chk(m_op == 2'b00 ? "R3 program bit7" : "R4 erase bit7", {7'b0, rd_data[7]}, {7'b0, e[7]});
            chk("R5 toggle and low bits", {1'b0, rd_data[6:0]}, {1'b0, e[6:0]});
        end else if (m_set > 0) begin
            chk("R7 settle byte", rd_data, e);
        end else begin
            chk("R8 passthrough", rd_data, e);
        end
        // model update at the coming edge
        if (m_busy) begin
            if (rd) m_tog = ~m_tog;
            if (m_rem == 1) begin m_busy = 1'b0; m_set = SET_C; end
            else m_rem--;
        end else begin
            if (m_set > 0) m_set--;
            if (st) begin
                m_busy = 1'b1; m_rem = op_len(o); m_op = o; m_b7 = pd[7];
                m_tog = 1'b1; m_set = 0;
            end
        end
    endtask

    task automatic idle(int n, bit rd);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, 8'h00, rd, 8'($urandom));
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        true_data = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset busy", {7'b0, busy}, 8'h00);
        chk("R1 reset data", rd_data, 8'h5A);
        rst_n = 1'b1;

        // R3: program with bit7 set, dense reads
        step(1'b1, 2'b00, 8'h80, 1'b0, 8'h11);
        idle(PROG_C, 1'b1);
        idle(SET_C + 2, 1'b1);   // R7 reads in settle do not toggle; R8 after
        // R3: program with bit7 clear, sparse reads
        step(1'b1, 2'b00, 8'h3C, 1'b0, 8'hF0);
        for (int i = 0; i < PROG_C + SET_C + 2; i++)
            step(1'b0, 2'b00, 8'h00, (i % 3) == 0, 8'($urandom));
        // R4: sector erase, R2 length
        step(1'b1, 2'b01, 8'hFF, 1'b0, 8'hFF);
        idle(SECT_C + SET_C + 1, 1'b1);
        // R4: chip erase with op 11
        step(1'b1, 2'b11, 8'h00, 1'b1, 8'h00);
        idle(CHIP_C + SET_C + 1, 1'b0);
        // R6: start while busy ignored (program, then chip request)
        step(1'b1, 2'b00, 8'h00, 1'b0, 8'h00);
        step(1'b1, 2'b10, 8'h80, 1'b1, 8'h00);
        step(1'b1, 2'b01, 8'h80, 1'b1, 8'h00);
        idle(PROG_C + 1, 1'b0);
        // R9: start during settle begins a new operation
        step(1'b1, 2'b01, 8'h80, 1'b0, 8'h00);
        idle(2, 1'b1);
        step(1'b1, 2'b00, 8'h00, 1'b1, 8'hAA);
        idle(PROG_C + SET_C + 1, 1'b1);

        // random mix
        for (int i = 0; i < 3000; i++)
            step(($urandom % 25) == 0, 2'($urandom), 8'($urandom),
                 1'($urandom), 8'($urandom));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule